// File: doc/BRIEF.md
# RISC Integer Arithmetic and Logic Unit

This block is the combinational execute stage of a small load/store RISC integer pipeline. It takes two register operands, a shift count and a 16-bit immediate. A 4-bit operation select, produced by an upstream decoder, picks one of thirteen functions. The block returns a 32-bit result and a flag that is high when that result is all zeros.

The functions are:

- addition and subtraction that wrap around;
- bitwise AND, OR and NOR, with NOR serving as the only complement;
- a signed less-than test that yields 0 or 1 in the full word;
- logical shifts of the second operand in either direction;
- a load-upper form that places the immediate in the top half of the word.

Four immediate forms take the immediate in place of the second operand: add, AND, OR and less-than.

A branch-on-equal or branch-on-not-equal issues a subtract and tests the zero flag. A full 32-bit constant is built in two steps: a load-upper followed by an OR-immediate.

Top module: `int_alu`

## Requirements
- R1: Select 0 (ADD) returns A+B modulo 2^32. Select 9 (ADDI) returns A plus the sign-extended immediate, also modulo 2^32. Neither form raises any exception.
- R2: Select 1 (SUB) returns A-B modulo 2^32.
- R3: Select 2 returns A AND B, select 3 returns A OR B, and select 4 returns NOT(A OR B). With B equal to zero, select 4 therefore gives the complement of A.
- R4: Select 10 (ANDI) returns A AND the zero-extended immediate. Select 11 (ORI) returns A OR the zero-extended immediate.
- R5: Select 5 (SLT) compares A with B as two's-complement values and returns 32'd1 when A is smaller, otherwise 32'd0. Select 12 (SLTI) does the same with the sign-extended immediate in place of B.
- R6: Select 6 shifts B left and select 7 shifts B right, both by the 5-bit shift count (0 to 31), filling vacated bits with zeros. Operand A has no effect on either result.
- R7: Select 8 (LUI) returns the immediate in bits 31:16 and zeros in bits 15:0. Feeding that result as A into ORI with a second immediate yields the 32-bit constant {first, second}.
- R8: The zero flag is high exactly when the result is all zeros. After a SUB it is therefore high exactly when A equals B.
- R9: The unused select codes 13, 14 and 15 return zero, with the zero flag high.
- R10: Every select that does not name the immediate ignores it, and every non-shift select ignores the shift count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation select code |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand, also the shifted value |
| shamt | input | 5 | Shift count |
| imm | input | 16 | Immediate field |
| result | output | 32 | Function result |
| zero_flag | output | 1 | High when result is all zeros |

## Verification
The signed comparison gets the most attention. Operand pairs whose difference overflows, such as 0x80000000 against 0x7FFFFFFF, catch a design that reads the raw sign of the difference; such a design reports the wrong ordering. Every shift count from 0 through 31 is swept, with dense bit patterns in A, to expose shifts that use the wrong operand or the wrong count. Immediates with bit 15 set separate sign extension from zero extension: getting it wrong corrupts the top half of ADDI and SLTI results or sets spurious high bits under ANDI and ORI. The unused codes, the load-upper then OR-immediate constant build, and register forms driven with changing immediates and shift counts catch stray decode paths that would leak a value into the result.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_LUI  = 4'd8,
        OP_ADDI = 4'd9,
        OP_ANDI = 4'd10,
        OP_ORI  = 4'd11,
        OP_SLTI = 4'd12
    } alu_op_e;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  alu_op_e              op,
    input  logic [DATA_W-1:0]    b_reg,
    input  logic [IMM_W-1:0]     imm,
    output logic [DATA_W-1:0]    b_eff,
    output logic                 do_sub
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;

    assign imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign imm_zext = {{EXT_W{1'b0}}, imm};

    always_comb begin
        b_eff  = b_reg;
        do_sub = 1'b0;
        unique case (op)
            OP_ADDI: b_eff = imm_sext;
            OP_SLTI: begin
                b_eff  = imm_sext;
                do_sub = 1'b1;
            end
            OP_ANDI,
            OP_ORI:  b_eff = imm_zext;
            OP_SUB,
            OP_SLT:  do_sub = 1'b1;
            default: b_eff = b_reg;
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              lt_signed
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_x;
    logic              ovf;

    assign b_x = b ^ {DATA_W{sub}};
    assign sum = a + b_x + {{(DATA_W-1){1'b0}}, sub};

    // Signed overflow: both addends share a sign that the sum lacks.
    assign ovf       = (a[MSB] == b_x[MSB]) && (sum[MSB] != a[MSB]);
    assign lt_signed = sum[MSB] ^ ovf;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] and_r,
    output logic [DATA_W-1:0] or_r,
    output logic [DATA_W-1:0] nor_r
);
    assign and_r = a & b;
    assign or_r  = a | b;
    assign nor_r = ~or_r;
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5,
    parameter int IMM_W   = 16
) (
    input  logic [DATA_W-1:0]  b,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [IMM_W-1:0]   imm,
    output logic [DATA_W-1:0]  shl,
    output logic [DATA_W-1:0]  shr,
    output logic [DATA_W-1:0]  upper
);
    // Staged barrel shifter, one stage per shift-count bit.
    logic [DATA_W-1:0] stl [SHAMT_W+1];
    logic [DATA_W-1:0] str [SHAMT_W+1];

    assign stl[0] = b;
    assign str[0] = b;

    for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
        assign stl[s+1] = shamt[s] ? (stl[s] << (1 << s)) : stl[s];
        assign str[s+1] = shamt[s] ? (str[s] >> (1 << s)) : str[s];
    end

    assign shl   = stl[SHAMT_W];
    assign shr   = str[SHAMT_W];
    assign upper = {imm, {(DATA_W-IMM_W){1'b0}}};
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [SH_W-1:0]   shamt,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic              zero_flag
);
    alu_op_e           op;
    logic [DATA_W-1:0] b_eff;
    logic              do_sub;
    logic [DATA_W-1:0] sum;
    logic              lt_s;
    logic [DATA_W-1:0] and_r, or_r, nor_r;
    logic [DATA_W-1:0] shl_r, shr_r, upper_r;

    assign op = alu_op_e'(op_sel);

    alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .op     (op),
        .b_reg  (opnd_b),
        .imm    (imm),
        .b_eff  (b_eff),
        .do_sub (do_sub)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a         (opnd_a),
        .b         (b_eff),
        .sub       (do_sub),
        .sum       (sum),
        .lt_signed (lt_s)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a     (opnd_a),
        .b     (b_eff),
        .and_r (and_r),
        .or_r  (or_r),
        .nor_r (nor_r)
    );

    alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SH_W), .IMM_W(IMM_W)) u_shift (
        .b     (opnd_b),
        .shamt (shamt),
        .imm   (imm),
        .shl   (shl_r),
        .shr   (shr_r),
        .upper (upper_r)
    );

    always_comb begin
        result = '0;
        unique case (op)
            OP_ADD, OP_ADDI, OP_SUB: result = sum;
            OP_AND, OP_ANDI:         result = and_r;
            OP_OR,  OP_ORI:          result = or_r;
            OP_NOR:                  result = nor_r;
            OP_SLT, OP_SLTI:         result = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLL:                  result = shl_r;
            OP_SRL:                  result = shr_r;
            OP_LUI:                  result = upper_r;
            default:                 result = '0;
        endcase
    end

    assign zero_flag = ~|result;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = 5
) (
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [SH_W-1:0]   shamt,
    input logic [IMM_W-1:0]  imm,
    input logic [DATA_W-1:0] result,
    input logic              zero_flag
);
    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b, shamt, imm})) begin
            if (op_sel == 4'd5 || op_sel == 4'd12) begin
                // R5
                slt_range_chk: assert (result[DATA_W-1:1] == '0);
            end
            if (op_sel == 4'd8) begin
                // R7
                lui_layout_chk: assert (result == {imm, {(DATA_W-IMM_W){1'b0}}});
            end
            if (op_sel >= 4'd13) begin
                // R9
                unused_code_chk: assert (result == '0 && zero_flag);
            end
            if (op_sel == 4'd1) begin
                // R8
                sub_equal_chk: assert (zero_flag == (opnd_a == opnd_b));
            end
            if (op_sel == 4'd4) begin
                // R3
                nor_disjoint_chk: assert ((result & (opnd_a | opnd_b)) == '0);
            end
            if ((op_sel == 4'd6 || op_sel == 4'd7) && shamt == '0) begin
                // R6
                shift_zero_chk: assert (result == opnd_b);
            end
        end
    end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_int_alu_chk (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .shamt     (shamt),
    .imm       (imm),
    .result    (result),
    .zero_flag (zero_flag)
);

// File: tb/test_int_alu.sv
module test_int_alu;
    logic        clk = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        zero_flag;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] rng = 32'h1BADF00D;

    always #4 clk = ~clk;

    int_alu i_int_alu (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shamt(shamt), .imm(imm), .result(result), .zero_flag(zero_flag)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] sh,
                                          input logic [15:0] im);
        logic [31:0] se, ze;
        se = {{16{im[15]}}, im};
        ze = {16'h0, im};
        case (op)
            4'd0:  return a + b;
            4'd1:  return a - b;
            4'd2:  return a & b;
            4'd3:  return a | b;
            4'd4:  return ~(a | b);
            4'd5:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd6:  return b << sh;
            4'd7:  return b >> sh;
            4'd8:  return {im, 16'h0};
            4'd9:  return a + se;
            4'd10: return a & ze;
            4'd11: return a | ze;
            4'd12: return ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd9:   return "R1";
            4'd1:         return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd10, 4'd11: return "R4";
            4'd5, 4'd12:  return "R5";
            4'd6, 4'd7:   return "R6";
            4'd8:         return "R7";
            default:      return "R9";
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, input logic [15:0] im);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; shamt = sh; imm = im;
        #2;
    endtask

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic [4:0] sh, input logic [15:0] im);
        logic [31:0] e;
        apply(op, a, b, sh, im);
        e = model(op, a, b, sh, im);
        check32(tag_of(op), result, e);
        // R8: flag follows an all-zero result
        check32("R8", {31'h0, zero_flag}, {31'h0, e == 32'h0});
    endtask

    logic [31:0] corner [8] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000,
                                32'h7FFFFFFF, 32'h0000FFFF, 32'hFFFF0000, 32'h55555555};
    logic [15:0] icorner [6] = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // Initial state with all inputs zero: ADD of zeros gives zero, flag high.
        #2;
        check32("R1", result, 32'h0);
        check32("R8", {31'h0, zero_flag}, 32'h1);

        // Corner sweep across every select code, including the unused R9 codes.
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    run_vec(4'(op), corner[i], corner[j], 5'((i * 8 + j) % 32),
                            icorner[(i + j) % 6]);
                end
            end
            for (int k = 0; k < 120; k++) begin
                logic [31:0] a, b;
                rng = next_rand(rng); a = rng;
                rng = next_rand(rng); b = rng;
                rng = next_rand(rng);
                run_vec(4'(op), a, b, rng[4:0], rng[31:16]);
            end
        end

        // R6: every shift count, with A varied to show it has no effect.
        for (int s = 0; s < 32; s++) begin
            run_vec(4'd6, 32'hFFFFFFFF, 32'h8000_0001, 5'(s), 16'h0);
            run_vec(4'd6, 32'h0, 32'hDEADBEEF, 5'(s), 16'hFFFF);
            run_vec(4'd7, 32'h12345678, 32'h8000_0001, 5'(s), 16'h0);
            run_vec(4'd7, 32'h0, 32'hDEADBEEF, 5'(s), 16'hFFFF);
        end

        // R5: overflow-prone signed orderings.
        run_vec(4'd5, 32'h80000000, 32'h7FFFFFFF, 5'd0, 16'h0);
        check32("R5", result, 32'd1);
        run_vec(4'd5, 32'h7FFFFFFF, 32'h80000000, 5'd0, 16'h0);
        check32("R5", result, 32'd0);
        run_vec(4'd12, 32'hFFFFFFFE, 32'h0, 5'd0, 16'hFFFF);
        check32("R5", result, 32'd1);

        // R3: NOR with B zero complements A.
        run_vec(4'd4, 32'hA5A5_0F0F, 32'h0, 5'd0, 16'h0);
        check32("R3", result, 32'h5A5A_F0F0);

        // R7: LUI followed by ORI builds a full constant.
        begin
            logic [31:0] hi;
            apply(4'd8, 32'h0, 32'h0, 5'd0, 16'hCAFE);
            hi = result;
            check32("R7", hi, 32'hCAFE_0000);
            apply(4'd11, hi, 32'h0, 5'd0, 16'hBABE);
            check32("R7", result, 32'hCAFE_BABE);
        end

        // R10: register forms ignore the immediate and non-shift forms the count.
        for (int op = 0; op < 6; op++) begin
            logic [31:0] r0;
            apply(4'(op), 32'h1357_9BDF, 32'h2468_ACE0, 5'd0, 16'h0000);
            r0 = result;
            apply(4'(op), 32'h1357_9BDF, 32'h2468_ACE0, 5'd31, 16'hFFFF);
            check32("R10", result, r0);
        end
        for (int op = 9; op < 13; op++) begin
            logic [31:0] r0;
            apply(4'(op), 32'h1357_9BDF, 32'h2468_ACE0, 5'd0, 16'h8421);
            r0 = result;
            apply(4'(op), 32'h1357_9BDF, 32'hFFFF_FFFF, 5'd17, 16'h8421);
            check32("R10", result, r0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule